// File: doc/BRIEF.md
# Serial Real-Time-Clock Register Slave

This block is the slave side of a three-wire serial register port for a real-time clock. A host raises a chip-enable, toggles a serial clock and moves bits over a shared data line. The block collects the first byte as a command, which carries a register address and a direction flag. For a write it collects the following data bytes and commits each complete byte. For a read it turns the data line around and shifts register contents out. One special address streams every clock register, with the control register last, in a single burst transfer.

The block keeps three kinds of state. The first is the seven time and date registers, held as BCD except day-of-week, which is binary. The second is a control register whose only live bit is a write-protect flag for the time registers. The last is a trickle-charge setting byte and a small RAM window. No oscillator runs here: time values change only when the host writes them. All host pins are assumed to be already synchronous to `clk`. The host serial clock must be several system clocks per phase.

Top module: `serial_rtc_regs`

## Requirements
- R1: A command byte is received least-significant bit first on rising serial-clock edges. Bit 7 must be 1. Bits 6:1 are the register address. Bit 0 is 1 for a read and 0 for a write.
- R2: Single-register writes and reads work for the time registers at address 0 (seconds), 1 (minutes), 2 (hours), 3 (day of month), 4 (month), 5 (day of week) and 6 (year), and a written byte reads back unchanged.
- R3: Address 7 is the control register. Only bit 7, the write-protect flag, is stored, and bits 6:0 always read as zero.
- R4: While write-protect is 1, writes to addresses 0 to 6 leave those registers unchanged. Writes to the control, trickle (address 8) and RAM addresses still take effect.
- R5: A write to address 0x1F (command 0xBE) is a burst. Data bytes go to addresses 0 through 7 in ascending order, and bytes after the eighth are dropped. The control byte comes last, so a burst can set write-protect for later transfers.
- R6: A read of address 0x1F (command 0xBF) streams addresses 0 through 7 in ascending order.
- R7: Chip-enable low aborts any transfer, and a partly received data byte is never committed. This holds even when chip-enable falls in the same system-clock cycle as the eighth rising serial-clock edge.
- R8: A burst read cut short by dropping chip-enable, for example after 7 bytes, changes no register.
- R9: On a read, the data-line enable rises on the first falling serial-clock edge after the last command bit. From that edge the block drives data bits LSB first, one per falling edge, and the enable drops once chip-enable is low. In every other phase the enable is low.
- R10: After reset, control reads 0x80, seconds, minutes, hours and year read 0x00, day of month, month and day of week read 0x01, and trickle reads 0x00.
- R11: Addresses 0x09 to 0x1E, and RAM-range addresses past the window, ignore writes and read 0x00.
- R12: A command byte with bit 7 clear makes the block ignore the rest of the transfer: nothing is written and the data line is not driven.
- R13: The RAM window starts at address 0x20 (commands 0xC0 for a write and 0xC1 for a read) and holds RAM_DEPTH bytes that can be read and written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Host chip-enable, active high |
| sclk | input | 1 | Host serial clock |
| dio_in | input | 1 | Data line as seen by the block |
| dio_out | output | 1 | Data bit driven by the block during a read |
| dio_oe | output | 1 | Enable for the block driving the data line |

## Verification
The delicate coincidence is an abort that lands on the same system-clock cycle as the edge that would complete a data byte. The cycle where chip-enable falls is also the one where the eighth rising serial-clock edge would commit a write. The bench provokes this by raising the serial clock and lowering chip-enable at the same instant, after seven data bits of a seconds write. It then reads seconds back and expects the old value. A second pairing is the burst whose final control byte re-arms write-protect. That case is judged by the next single write to seconds being refused.

// File: rtl/srtc_pkg.sv
package srtc_pkg;

    localparam int ADDR_W    = 6;
    localparam int BYTE_W    = 8;
    localparam int TIME_REGS = 7;
    localparam int BURST_LEN = 8;

    localparam logic [ADDR_W-1:0] A_CTRL     = 6'h07;
    localparam logic [ADDR_W-1:0] A_TRICKLE  = 6'h08;
    localparam logic [ADDR_W-1:0] A_BURST    = 6'h1F;
    localparam logic [ADDR_W-1:0] A_RAM_BASE = 6'h20;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WR,
        PH_RD,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              is_read;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.valid   = b[7];
        c.addr    = b[6:1];
        c.is_read = b[0];
        return c;
    endfunction

    // date, month and day-of-week start at 1, the rest at 0
    function automatic logic [BYTE_W-1:0] time_reset(input int idx);
        return (idx >= 3 && idx <= 5) ? 8'h01 : 8'h00;
    endfunction

endpackage

// File: rtl/srtc_edge.sv
module srtc_edge (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign rise = ce & sclk & ~sclk_q;
    assign fall = ce & ~sclk & sclk_q;
endmodule

// File: rtl/srtc_shifter.sv
module srtc_shifter
    import srtc_pkg::*;
#(
    parameter int BURST_LEN_P = BURST_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              dout,
    output logic              oe
);
    localparam int IDX_W = $clog2(BURST_LEN_P);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    phase_e            phase;
    logic [BYTE_W-2:0] in_sh;
    logic [BYTE_W-1:0] out_sh;
    logic [BYTE_W-1:0] in_next;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr_q;
    logic              burst_q;
    logic              burst_done;
    logic              rd_started;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  idx_rd;
    cmd_t              cmd;

    // serial data arrives LSB first: new bit enters at the top
    assign in_next = {din, in_sh};
    assign cmd     = decode_cmd(in_next);
    assign idx_rd  = rd_started ? idx + 1'b1 : idx;
    assign rd_addr = burst_q ? ADDR_W'(idx_rd) : addr_q;

    always_ff @(posedge clk) begin
        if (rst || !ce) begin
            phase      <= PH_CMD;
            in_sh      <= '0;
            out_sh     <= '0;
            cnt        <= '0;
            addr_q     <= '0;
            burst_q    <= 1'b0;
            burst_done <= 1'b0;
            rd_started <= 1'b0;
            idx        <= '0;
            wr_stb     <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            dout       <= 1'b0;
            oe         <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            unique case (phase)
                PH_CMD: if (rise) begin
                    in_sh <= in_next[BYTE_W-1:1];
                    if (cnt == LAST) begin
                        cnt     <= '0;
                        addr_q  <= cmd.addr;
                        burst_q <= (cmd.addr == A_BURST);
                        idx     <= '0;
                        if (!cmd.valid)       phase <= PH_SKIP;
                        else if (cmd.is_read) phase <= PH_RD;
                        else                  phase <= PH_WR;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_WR: if (rise) begin
                    in_sh <= in_next[BYTE_W-1:1];
                    if (cnt == LAST) begin
                        cnt <= '0;
                        if (!burst_done) begin
                            wr_stb  <= 1'b1;
                            wr_addr <= burst_q ? ADDR_W'(idx) : addr_q;
                            wr_data <= in_next;
                        end
                        if (burst_q) begin
                            if (idx == IDX_W'(BURST_LEN_P - 1)) burst_done <= 1'b1;
                            idx <= idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_RD: if (fall) begin
                    oe <= 1'b1;
                    if (!rd_started || cnt == FULL) begin
                        out_sh     <= rd_data;
                        dout       <= rd_data[0];
                        cnt        <= CNT_W'(1);
                        rd_started <= 1'b1;
                        if (rd_started && burst_q) idx <= idx + 1'b1;
                    end else begin
                        dout <= out_sh[cnt[BIT_W-1:0]];
                        cnt  <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/srtc_regfile.sv
module srtc_regfile
    import srtc_pkg::*;
#(
    parameter int RAM_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int RAM_AW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;
    localparam logic [ADDR_W-1:0] RAM_END = A_RAM_BASE + ADDR_W'(RAM_DEPTH);

    logic [BYTE_W-1:0] tval [TIME_REGS];
    logic [BYTE_W-1:0] rval [RAM_DEPTH];
    logic              wp;
    logic [BYTE_W-1:0] trickle;

    for (genvar g = 0; g < TIME_REGS; g++) begin : g_time
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= time_reset(g);
            else if (wr_stb && !wp && wr_addr == ADDR_W'(g))
                q <= wr_data;
        end
        assign tval[g] = q;
    end

    for (genvar g = 0; g < RAM_DEPTH; g++) begin : g_ram
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_stb && wr_addr == A_RAM_BASE + ADDR_W'(g))
                q <= wr_data;
        end
        assign rval[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp      <= 1'b1;
            trickle <= '0;
        end else if (wr_stb) begin
            if (wr_addr == A_CTRL)    wp      <= wr_data[7];
            if (wr_addr == A_TRICKLE) trickle <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_W'(TIME_REGS))
            rd_data = tval[rd_addr[2:0]];
        else if (rd_addr == A_CTRL)
            rd_data = {wp, 7'b0};
        else if (rd_addr == A_TRICKLE)
            rd_data = trickle;
        else if (rd_addr >= A_RAM_BASE && rd_addr < RAM_END)
            rd_data = rval[rd_addr[RAM_AW-1:0]];
    end
endmodule

// File: rtl/serial_rtc_regs.sv
module serial_rtc_regs
    import srtc_pkg::*;
#(
    parameter int RAM_DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic sclk,
    input  logic dio_in,
    output logic dio_out,
    output logic dio_oe
);
    logic              rise;
    logic              fall;
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [BYTE_W-1:0] rd_data;

    srtc_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .ce   (ce),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    srtc_shifter #(.BURST_LEN_P(BURST_LEN)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .rise    (rise),
        .fall    (fall),
        .din     (dio_in),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dout    (dio_out),
        .oe      (dio_oe)
    );

    srtc_regfile #(.RAM_DEPTH(RAM_DEPTH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/srtc_chk.sv
module srtc_chk
    import srtc_pkg::*;
#(
    parameter int RAM_DEPTH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ce,
    input logic              rise,
    input logic              fall,
    input logic              dio_oe,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [BYTE_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] RAM_END = A_RAM_BASE + ADDR_W'(RAM_DEPTH);

    // R9
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> !dio_oe);

    // R9
    oe_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dio_oe) |-> $past(fall));

    // R7
    commit_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> ($past(ce) && $past(rise)));

    // R3
    ctrl_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == A_CTRL) |-> (rd_data[6:0] == 7'd0));

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((rd_addr > A_TRICKLE && rd_addr < A_RAM_BASE) || rd_addr >= RAM_END)
        |-> (rd_data == 8'h00));
endmodule

bind serial_rtc_regs srtc_chk #(.RAM_DEPTH(RAM_DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .rise    (rise),
    .fall    (fall),
    .dio_oe  (dio_oe),
    .wr_stb  (wr_stb),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/sim_serial_rtc_regs.sv
module sim_serial_rtc_regs;
    localparam int HALF = 4;  // system clocks per serial-clock phase

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b0;
    logic sclk = 1'b0;
    logic dio_in = 1'b0;
    logic dio_out;
    logic dio_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    serial_rtc_regs u0 (
        .clk(clk), .rst(rst), .ce(ce), .sclk(sclk),
        .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe)
    );

    // {write cmd, write data, read cmd, expected}
    localparam logic [31:0] VEC [15] = '{
        32'h8E_00_8F_00, 32'h80_59_81_59, 32'h82_47_83_47, 32'h84_23_85_23,
        32'h86_31_87_31, 32'h88_12_89_12, 32'h8A_07_8B_07, 32'h8C_99_8D_99,
        32'h8E_FF_8F_80, 32'h80_11_81_59, 32'h90_A5_91_A5, 32'hC0_3C_C1_3C,
        32'hCE_96_CF_96, 32'h92_55_93_00, 32'h8E_00_8F_00
    };

    function automatic string vec_tag(input int i);
        if (i == 0 || i == 8 || i == 14) return "R3";
        if (i == 9 || i == 10) return "R4";
        if (i == 11 || i == 12) return "R13";
        if (i == 13) return "R11";
        return "R2";
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        sclk = 1'b0; dio_in = b; wait_clk(HALF);
        sclk = 1'b1; wait_clk(HALF);
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) put_bit(b[i]);  // R1: LSB first
    endtask

    task automatic get_byte(output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b0; wait_clk(HALF);
            b[i] = dio_out;
            sclk = 1'b1; wait_clk(HALF);
        end
    endtask

    task automatic begin_xfer();
        @(negedge clk); sclk = 1'b0; ce = 1'b1; wait_clk(HALF);
    endtask

    task automatic end_xfer();
        sclk = 1'b0; wait_clk(HALF);
        ce = 1'b0; wait_clk(HALF);
    endtask

    task automatic reg_write(input logic [7:0] cmd, input logic [7:0] d);
        begin_xfer(); put_byte(cmd); put_byte(d); end_xfer();
    endtask

    task automatic reg_read(input logic [7:0] cmd, output logic [7:0] d);
        begin_xfer(); put_byte(cmd); get_byte(d); end_xfer();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog got=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] burst [8];
        burst = '{8'h30, 8'h15, 8'h08, 8'h21, 8'h06, 8'h03, 8'h24, 8'h80};

        wait_clk(5); rst = 1'b0; wait_clk(3);

        // R10 reset values
        check("R10 oe", {7'd0, dio_oe}, 8'h00);
        reg_read(8'h81, v); check("R10 sec", v, 8'h00);
        reg_read(8'h87, v); check("R10 date", v, 8'h01);
        reg_read(8'h89, v); check("R10 month", v, 8'h01);
        reg_read(8'h8B, v); check("R10 dow", v, 8'h01);
        reg_read(8'h8F, v); check("R10 ctrl", v, 8'h80);
        reg_read(8'h91, v); check("R10 trickle", v, 8'h00);

        // R4 protected at reset
        reg_write(8'h80, 8'h45);
        reg_read(8'h81, v); check("R4 wp at reset", v, 8'h00);

        // R1 / R2 table of single-register transfers
        for (int i = 0; i < 15; i++) begin
            reg_write(VEC[i][31:24], VEC[i][23:16]);
            reg_read(VEC[i][15:8], v);
            check(vec_tag(i), v, VEC[i][7:0]);
        end

        // R5 burst write, control byte last sets write-protect
        begin_xfer(); put_byte(8'hBE);
        for (int i = 0; i < 8; i++) put_byte(burst[i]);
        put_byte(8'h77);  // ninth byte dropped
        end_xfer();

        // R6 burst read in ascending order; R9 enable timing
        begin_xfer(); put_byte(8'hBF);
        check("R9 oe before data", {7'd0, dio_oe}, 8'h00);
        for (int i = 0; i < 8; i++) begin
            get_byte(v);
            check("R6 burst byte", v, burst[i]);
        end
        check("R9 oe during read", {7'd0, dio_oe}, 8'h01);
        end_xfer();
        check("R9 oe released", {7'd0, dio_oe}, 8'h00);

        reg_write(8'h80, 8'h00);
        reg_read(8'h81, v); check("R5 burst re-protect", v, 8'h30);

        // R8 truncated burst read
        begin_xfer(); put_byte(8'hBF);
        for (int i = 0; i < 7; i++) get_byte(v);
        end_xfer();
        reg_read(8'h8F, v); check("R8 ctrl", v, 8'h80);
        reg_read(8'h83, v); check("R8 min", v, 8'h15);

        // R7 partial byte abort
        reg_write(8'h8E, 8'h00);
        begin_xfer(); put_byte(8'h80);
        for (int i = 0; i < 5; i++) put_bit(1'b1);
        end_xfer();
        reg_read(8'h81, v); check("R7 partial", v, 8'h30);

        // R7 abort coinciding with the eighth rising edge
        begin_xfer(); put_byte(8'h80);
        for (int i = 0; i < 7; i++) put_bit(1'b1);
        sclk = 1'b0; dio_in = 1'b1; wait_clk(HALF);
        sclk = 1'b1; ce = 1'b0; wait_clk(HALF);
        sclk = 1'b0; wait_clk(HALF);
        reg_read(8'h81, v); check("R7 same-cycle abort", v, 8'h30);

        // R12 command with bit 7 clear
        reg_write(8'h00, 8'h77);
        reg_read(8'h81, v); check("R12 write ignored", v, 8'h30);
        begin_xfer(); put_byte(8'h01); get_byte(v);
        check("R12 no drive", {7'd0, dio_oe}, 8'h00);
        end_xfer();

        // R11 RAM-range address past the window
        reg_write(8'hD0, 8'h5A);
        reg_read(8'hD1, v); check("R11 past window", v, 8'h00);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule